// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one complete NAND flash operation on an 8-bit NAND bus after software has loaded a handful of registers. Software fills in the address words, the byte count of the data phase and, if the operation needs one, a second command byte. It then writes a launch word that carries the opcode, the direction of the data phase and the number of address cycles. The engine then drives the bus through a fixed order of phases: a command latch, the address cycles, an optional data phase, an optional second command, a guard delay, and a wait for the ready/busy line. At the end it raises interrupt flags.

Because the second command sits in its own register, operations made of two commands complete as one hardware transaction. Examples are program followed by its confirm, block erase, and a large-page read followed by its start command. Data moves between the bus and an internal byte buffer. The host fills and reads that buffer through a separate byte port. Every strobe width is counted in clocks and is set by software.

Top module: `nand_op_engine`

## Requirements
- R1: After reset, CE#, WE# and RE# are high, CLE, ALE and the data-bus enable are low, and `irq` is low. The status register (word 10) and the interrupt status register (word 8) both read 0.
- R2: A write to the launch register (word 0) starts an operation only when bit 31 is set and the engine is idle. While the operation runs, bit 0 of the status register reads 1.
- R3: The opcode in bits 7:0 of the launch word is the first byte sent. It is latched with CLE high and ALE low.
- R4: When bit 30 of the launch word is set, the engine sends (bits 29:27)+1 address bytes with ALE high, least significant byte first. Byte 0 comes from bits 7:0 of word 2, byte 1 from bits 15:8 of word 2, and bytes 2 onward from word 3, low byte first.
- R5: When bit 25 of the launch word is set and the length register (word 4) is non-zero, the engine writes that many bytes onto the bus, taken from buffer index 0 upward.
- R6: When bit 26 is set and the length is non-zero, the engine pulses RE# that many times and stores the captured bytes at buffer index 0 upward, leaving the other buffer bytes untouched. When neither bit 25 nor bit 26 is set, there is no data phase.
- R7: When bit 8 of word 1 is set, the engine latches bits 7:0 of word 1 with CLE high after the address and data phases. When bit 8 is clear, no second command is sent.
- R8: After the last bus byte, the engine waits the high time plus the guard count (word 6, bits 7:0) before it samples ready.
- R9: When an operation completes, bit 31 of word 8 is set. Bit 28 is also set if a data phase ran. Writing 1 to a flag clears it. `irq` is the OR of the flags that are enabled by a 1 in word 9.
- R10: WE# low lasts word 5 bits 7:0 clocks, and a field value of 0 counts as one clock.
- R11: A launch write that arrives while the engine is busy is ignored, and the launch register keeps its value. A write to word 8 while the engine is idle starts nothing.
- R12: If ready stays low beyond the count in word 7, the engine returns to idle with bit 0 of word 8 set and bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| host_buf_we | input | 1 | Host buffer byte write |
| host_buf_addr | input | BUF_AW | Host buffer byte index |
| host_buf_wdata | input | 8 | Host buffer write byte |
| host_buf_rdata | output | 8 | Host buffer read byte |
| nand_ce_n | output | 1 | Chip enable, low during an operation |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_dq_o | output | 8 | Bus output byte |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus input byte |
| nand_rb_n | input | 1 | Ready (high) / busy (low) |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench records every byte latched on a rising WE# edge, together with its CLE and ALE levels. From that record it can catch an address byte order that is reversed, an off-by-one in the address count, or a second command that is dropped or sent before the data. A read whose byte count is wrong is caught by a buffer byte just past the length that must keep its old value. A wrong zero-field rule is caught by the pulse widths measured with the timing field at 0 and at 3, and the exact clock count from the last WE# rise to the release of CE#. A launch accepted while busy shows up in the launch-register readback and in extra bus bytes. A timeout that also reported completion shows up in the flag pattern.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_ADDR, ST_WDAT, ST_RDAT, ST_CMD2, ST_TWB, ST_WRB
   } seq_st_e;

   typedef enum logic [1:0] {PH_SET, PH_LO, PH_HI} sub_ph_e;

   localparam logic [3:0] RA_GO    = 4'd0;
   localparam logic [3:0] RA_CMD2  = 4'd1;
   localparam logic [3:0] RA_ADRLO = 4'd2;
   localparam logic [3:0] RA_ADRHI = 4'd3;
   localparam logic [3:0] RA_DLEN  = 4'd4;
   localparam logic [3:0] RA_TIMA  = 4'd5;
   localparam logic [3:0] RA_TIMB  = 4'd6;
   localparam logic [3:0] RA_TOUT  = 4'd7;
   localparam logic [3:0] RA_ISTAT = 4'd8;
   localparam logic [3:0] RA_IMASK = 4'd9;
   localparam logic [3:0] RA_STAT  = 4'd10;

   localparam int GO_START = 31;
   localparam int GO_AEN   = 30;
   localparam int GO_RD    = 26;
   localparam int GO_WR    = 25;

   localparam logic [31:0] FLAG_BITS = 32'h9000_0001;

   // a zero timing field still lasts one clock
   function automatic logic [7:0] clk_cnt(input logic [7:0] f);
      return (f == 8'd0) ? 8'd1 : f;
   endfunction
endpackage

// File: rtl/nseq_rb_sync.sv
module nseq_rb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_raw,
   output logic rb_sync
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign rb_sync = rb_raw;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         logic [STAGES:0]   sh_nxt;
         assign sh_nxt = {sh, rb_raw};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= sh_nxt[STAGES-1:0];
         end
         assign rb_sync = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nseq_pagebuf.sv
module nseq_pagebuf #(
   parameter int unsigned DEPTH = 2112,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [7:0]    h_wdata,
   output logic [7:0]    h_rdata,
   input  logic          e_we,
   input  logic [AW-1:0] e_addr,
   input  logic [7:0]    e_wdata,
   output logic [7:0]    e_rdata
);
   logic [7:0] mem [DEPTH];

   // engine write is placed last so it wins a same-index collision
   always_ff @(posedge clk) begin
      if (h_we) mem[h_addr] <= h_wdata;
      if (e_we) mem[e_addr] <= e_wdata;
   end

   assign h_rdata = mem[h_addr];
   assign e_rdata = mem[e_addr];
endmodule

// File: rtl/nseq_regs.sv
module nseq_regs
   import nseq_pkg::*;
#(
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned TOUT_W    = 32,
   parameter int unsigned TOUT_INIT = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [3:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              busy,
   input  logic              set_done,
   input  logic              set_xfer,
   input  logic              set_tout,
   output logic              go_fire,
   output logic [31:0]       go_q,
   output logic [8:0]        cmd2,
   output logic [15:0]       adr_lo,
   output logic [31:0]       adr_hi,
   output logic [LEN_W-1:0]  dlen,
   output logic [23:0]       tim_a,
   output logic [15:0]       tim_b,
   output logic [TOUT_W-1:0] tout,
   output logic [31:0]       istat,
   output logic              irq
);
   logic [31:0] imask;
   logic [31:0] sets;
   logic [31:0] clr;

   assign go_fire = wr && (addr == RA_GO) && wdata[GO_START] && !busy;
   assign sets    = {set_done, 2'b00, set_xfer, 27'd0, set_tout};
   assign clr     = (wr && addr == RA_ISTAT) ? wdata : 32'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q   <= '0;
         cmd2   <= '0;
         adr_lo <= '0;
         adr_hi <= '0;
         dlen   <= '0;
         tim_a  <= '0;
         tim_b  <= '0;
         tout   <= TOUT_W'(TOUT_INIT);
         imask  <= '0;
         istat  <= '0;
      end else begin
         if (go_fire) go_q <= wdata;
         if (wr) begin
            case (addr)
               RA_CMD2:  cmd2   <= wdata[8:0];
               RA_ADRLO: adr_lo <= wdata[15:0];
               RA_ADRHI: adr_hi <= wdata;
               RA_DLEN:  dlen   <= wdata[LEN_W-1:0];
               RA_TIMA:  tim_a  <= wdata[23:0];
               RA_TIMB:  tim_b  <= wdata[15:0];
               RA_TOUT:  tout   <= wdata[TOUT_W-1:0];
               RA_IMASK: imask  <= wdata & FLAG_BITS;
               default: ;
            endcase
         end
         // a new event wins over a clear in the same cycle
         istat <= ((istat & ~clr) | sets) & FLAG_BITS;
      end
   end

   assign irq = |(istat & imask);

   always_comb begin
      case (addr)
         RA_GO:    rdata = go_q;
         RA_CMD2:  rdata = {23'd0, cmd2};
         RA_ADRLO: rdata = {16'd0, adr_lo};
         RA_ADRHI: rdata = adr_hi;
         RA_DLEN:  rdata = 32'(dlen);
         RA_TIMA:  rdata = {8'd0, tim_a};
         RA_TIMB:  rdata = {16'd0, tim_b};
         RA_TOUT:  rdata = 32'(tout);
         RA_ISTAT: rdata = istat;
         RA_IMASK: rdata = imask;
         RA_STAT:  rdata = {31'd0, busy};
         default:  rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/nseq_core.sv
module nseq_core
   import nseq_pkg::*;
#(
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned TOUT_W = 32,
   parameter int unsigned AW     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_fire,
   input  logic [7:0]        go_op,
   input  logic              go_rd,
   input  logic              go_wr,
   input  logic              go_aen,
   input  logic [2:0]        go_ncyc,
   input  logic [8:0]        cmd2,
   input  logic [15:0]       adr_lo,
   input  logic [31:0]       adr_hi,
   input  logic [LEN_W-1:0]  dlen,
   input  logic [23:0]       tim_a,
   input  logic [15:0]       tim_b,
   input  logic [TOUT_W-1:0] tout,
   input  logic              rb,
   input  logic [7:0]        dq_i,
   input  logic [7:0]        buf_rdata,
   output logic              busy,
   output logic              set_done,
   output logic              set_xfer,
   output logic              set_tout,
   output logic              buf_we,
   output logic [AW-1:0]     buf_addr,
   output logic [7:0]        buf_wdata,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic              ce_n,
   output logic [7:0]        dq_o,
   output logic              dq_oe
);
   seq_st_e          st, nxt, data_st, tail_st;
   sub_ph_e          ph;
   logic [7:0]       cnt;
   logic [LEN_W-1:0] idx;
   logic [TOUT_W-1:0] tocnt;
   logic [7:0]       l_op;
   logic             l_rd, l_wr, l_aen;
   logic [2:0]       l_ncyc;

   logic [7:0] t_lo, t_hi, t_su, t_wb, t_rs, t_cap;
   logic       ph_end, byte_last, bus_st;
   logic [63:0] adr_all;
   logic [7:0]  abyte;

   assign t_lo  = clk_cnt(tim_a[7:0]);
   assign t_hi  = clk_cnt(tim_a[15:8]);
   assign t_su  = clk_cnt(tim_a[23:16]);
   assign t_wb  = clk_cnt(tim_b[7:0]);
   assign t_rs  = clk_cnt(tim_b[15:8]);
   assign t_cap = (t_rs < t_lo) ? t_rs : t_lo;

   assign adr_all = {16'd0, adr_hi, adr_lo};
   assign abyte   = adr_all[{idx[2:0], 3'b000} +: 8];

   always_comb begin
      case (ph)
         PH_SET:  ph_end = (cnt == t_su - 8'd1);
         PH_LO:   ph_end = (cnt == t_lo - 8'd1);
         default: ph_end = (cnt == t_hi - 8'd1);
      endcase
   end

   assign tail_st = cmd2[8] ? ST_CMD2 : ST_TWB;
   assign data_st = (l_wr && dlen != '0) ? ST_WDAT :
                    (l_rd && dlen != '0) ? ST_RDAT : tail_st;

   always_comb begin
      byte_last = 1'b1;
      nxt       = ST_TWB;
      case (st)
         ST_CMD:  nxt = l_aen ? ST_ADDR : data_st;
         ST_ADDR: begin
            byte_last = (idx == LEN_W'(l_ncyc));
            nxt       = data_st;
         end
         ST_WDAT, ST_RDAT: begin
            byte_last = (idx == dlen - LEN_W'(1));
            nxt       = tail_st;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_SET;
         cnt    <= '0;
         idx    <= '0;
         tocnt  <= '0;
         l_op   <= '0;
         l_rd   <= 1'b0;
         l_wr   <= 1'b0;
         l_aen  <= 1'b0;
         l_ncyc <= '0;
      end else begin
         case (st)
            ST_IDLE: if (go_fire) begin
               l_op   <= go_op;
               l_rd   <= go_rd;
               l_wr   <= go_wr;
               l_aen  <= go_aen;
               l_ncyc <= go_ncyc;
               st     <= ST_CMD;
               ph     <= PH_SET;
               cnt    <= '0;
               idx    <= '0;
            end
            ST_CMD, ST_ADDR, ST_WDAT, ST_RDAT, ST_CMD2: begin
               if (!ph_end) cnt <= cnt + 8'd1;
               else begin
                  cnt <= '0;
                  case (ph)
                     PH_SET: ph <= PH_LO;
                     PH_LO:  ph <= PH_HI;
                     default: begin
                        if (!byte_last) begin
                           idx <= idx + LEN_W'(1);
                           ph  <= (st == ST_RDAT) ? PH_LO : PH_SET;
                        end else begin
                           idx <= '0;
                           st  <= nxt;
                           ph  <= (nxt == ST_RDAT) ? PH_LO : PH_SET;
                        end
                     end
                  endcase
               end
            end
            ST_TWB: begin
               if (cnt == t_wb - 8'd1) begin
                  st    <= ST_WRB;
                  cnt   <= '0;
                  tocnt <= '0;
               end else cnt <= cnt + 8'd1;
            end
            ST_WRB: begin
               if (rb || tocnt == tout) st <= ST_IDLE;
               else tocnt <= tocnt + TOUT_W'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign set_done = (st == ST_WRB) && rb;
   assign set_tout = (st == ST_WRB) && !rb && (tocnt == tout);
   assign set_xfer = (st == ST_WDAT || st == ST_RDAT) && ph == PH_HI && ph_end && byte_last;

   assign buf_addr  = idx[AW-1:0];
   assign buf_we    = (st == ST_RDAT) && ph == PH_LO && (cnt == t_cap - 8'd1);
   assign buf_wdata = dq_i;

   assign bus_st = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_WDAT) || (st == ST_CMD2);
   assign ce_n   = (st == ST_IDLE);
   assign cle    = (st == ST_CMD) || (st == ST_CMD2);
   assign ale    = (st == ST_ADDR);
   assign we_n   = !(bus_st && ph == PH_LO);
   assign re_n   = !((st == ST_RDAT) && ph == PH_LO);
   assign dq_oe  = bus_st;

   always_comb begin
      case (st)
         ST_CMD:  dq_o = l_op;
         ST_ADDR: dq_o = abyte;
         ST_WDAT: dq_o = buf_rdata;
         ST_CMD2: dq_o = cmd2[7:0];
         default: dq_o = 8'd0;
      endcase
   end
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
   import nseq_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 2112,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned TOUT_W    = 32,
   parameter int unsigned TOUT_INIT = 100000,
   parameter int unsigned RB_SYNC   = 2,
   parameter int unsigned BUF_AW    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              host_buf_we,
   input  logic [BUF_AW-1:0] host_buf_addr,
   input  logic [7:0]        host_buf_wdata,
   output logic [7:0]        host_buf_rdata,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [7:0]        nand_dq_o,
   output logic              nand_dq_oe,
   input  logic [7:0]        nand_dq_i,
   input  logic              nand_rb_n,
   output logic              irq
);
   if (BUF_BYTES < 2) begin : g_bad_buf
      $error("BUF_BYTES must be at least 2");
   end
   if (BUF_AW > LEN_W) begin : g_bad_len
      $error("LEN_W too narrow for the buffer");
   end
   if (TOUT_W > 32 || TOUT_W < 1) begin : g_bad_tout
      $error("TOUT_W must be 1..32");
   end

   logic              busy, go_fire, set_done, set_xfer, set_tout, rb_s;
   logic [31:0]       go_q, istat;
   logic [8:0]        cmd2;
   logic [15:0]       adr_lo;
   logic [31:0]       adr_hi;
   logic [LEN_W-1:0]  dlen;
   logic [23:0]       tim_a;
   logic [15:0]       tim_b;
   logic [TOUT_W-1:0] tout;
   logic              e_we;
   logic [BUF_AW-1:0] e_addr;
   logic [7:0]        e_wdata, e_rdata;

   nseq_regs #(.LEN_W(LEN_W), .TOUT_W(TOUT_W), .TOUT_INIT(TOUT_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(busy), .set_done(set_done), .set_xfer(set_xfer),
      .set_tout(set_tout), .go_fire(go_fire), .go_q(go_q), .cmd2(cmd2),
      .adr_lo(adr_lo), .adr_hi(adr_hi), .dlen(dlen), .tim_a(tim_a), .tim_b(tim_b),
      .tout(tout), .istat(istat), .irq(irq));

   nseq_rb_sync #(.STAGES(RB_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .rb_raw(nand_rb_n), .rb_sync(rb_s));

   nseq_pagebuf #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) u_buf (
      .clk(clk), .h_we(host_buf_we), .h_addr(host_buf_addr), .h_wdata(host_buf_wdata),
      .h_rdata(host_buf_rdata), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata),
      .e_rdata(e_rdata));

   nseq_core #(.LEN_W(LEN_W), .TOUT_W(TOUT_W), .AW(BUF_AW)) u_core (
      .clk(clk), .rst_n(rst_n), .go_fire(go_fire),
      .go_op(reg_wdata[7:0]), .go_rd(reg_wdata[GO_RD]), .go_wr(reg_wdata[GO_WR]),
      .go_aen(reg_wdata[GO_AEN]), .go_ncyc(reg_wdata[29:27]),
      .cmd2(cmd2), .adr_lo(adr_lo), .adr_hi(adr_hi), .dlen(dlen), .tim_a(tim_a),
      .tim_b(tim_b), .tout(tout), .rb(rb_s), .dq_i(nand_dq_i), .buf_rdata(e_rdata),
      .busy(busy), .set_done(set_done), .set_xfer(set_xfer), .set_tout(set_tout),
      .buf_we(e_we), .buf_addr(e_addr), .buf_wdata(e_wdata),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .ce_n(nand_ce_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe));
endmodule

// File: rtl/nand_op_engine_chk.sv
module nand_op_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        cle,
   input logic        ale,
   input logic        we_n,
   input logic        re_n,
   input logic        ce_n,
   input logic        dq_oe,
   input logic [31:0] go_q,
   input logic [31:0] istat
);
   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R4
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ce_n && we_n && re_n && !cle && !ale && !dq_oe)); // R1
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe); // R6
   AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n) $past(busy) |-> $stable(go_q)); // R11
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(istat[31]) |-> (!busy && $past(busy))); // R9
   AST_TOUT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(istat[0]) |-> (!busy && $past(busy) && !istat[31])); // R12
endmodule

bind nand_op_engine nand_op_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .cle(nand_cle), .ale(nand_ale),
   .we_n(nand_we_n), .re_n(nand_re_n), .ce_n(nand_ce_n), .dq_oe(nand_dq_oe),
   .go_q(go_q), .istat(istat));

// File: tb/sim_nand_op_engine.sv
module sim_nand_op_engine;
   localparam int AW = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        host_buf_we = 1'b0;
   logic [AW-1:0] host_buf_addr = '0;
   logic [7:0]  host_buf_wdata = '0;
   logic [7:0]  host_buf_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq;
   logic [7:0]  nand_dq_o, nand_dq_i;
   logic        rb = 1'b1;

   int n_chk = 0, n_fail = 0;
   bit ended = 0;

   logic [9:0] blog [0:63];
   int nlog = 0;
   int rcount = 0;
   int wcnt = 0, wlast = 0;
   int gcnt = 0, glast = 0;

   always #4 clk = ~clk;

   nand_op_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_buf_we(host_buf_we),
      .host_buf_addr(host_buf_addr), .host_buf_wdata(host_buf_wdata),
      .host_buf_rdata(host_buf_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
      .nand_rb_n(rb), .irq(irq));

   // flash model: latch log, read data source, pulse-width meters
   assign nand_dq_i = nand_re_n ? 8'h00 : (8'hA0 + 8'(rcount));

   always @(posedge nand_we_n) if (rst_n && !nand_ce_n) begin
      if (nlog < 64) blog[nlog] = {nand_cle, nand_ale, nand_dq_o};
      nlog++;
      wlast = wcnt; wcnt = 0; gcnt = 0;
   end
   always @(posedge nand_re_n) if (rst_n && !nand_ce_n) rcount++;
   always @(posedge clk) begin
      if (!nand_we_n) wcnt++;
      gcnt++;
   end
   always @(posedge nand_ce_n) if (rst_n) glast = gcnt;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wreg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic bwr(input int a, input logic [7:0] d);
      @(negedge clk); host_buf_we = 1'b1; host_buf_addr = AW'(a); host_buf_wdata = d;
      @(negedge clk); host_buf_we = 1'b0;
   endtask

   task automatic brd(input int a, output logic [7:0] d);
      @(negedge clk); host_buf_addr = AW'(a); #1 d = host_buf_rdata;
   endtask

   task automatic wait_idle;
      logic [31:0] s;
      for (int i = 0; i < 20000; i++) begin
         rreg(4'd10, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   task automatic finish_up;
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      @(negedge clk);
      chk("R1 pins", {25'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, irq},
          32'b1110000);
      rreg(4'd10, d); chk("R1 status", d, 32'd0);
      rreg(4'd8, d);  chk("R1 istat", d, 32'd0);
   endtask

   task automatic t_nostart;
      logic [31:0] d;
      nlog = 0;
      wreg(4'd0, 32'h0000_0070);
      repeat (10) @(negedge clk);
      rreg(4'd10, d); chk("R2 no launch without bit31", d, 32'd0);
      wreg(4'd8, 32'hFFFF_FFFF);
      repeat (10) @(negedge clk);
      rreg(4'd10, d); chk("R11 flag write while idle starts nothing", d, 32'd0);
      chk("R11 no bus bytes", 32'(nlog), 32'd0);
   endtask

   task automatic t_erase;
      logic [31:0] d;
      wreg(4'd2, 32'h3456); wreg(4'd3, 32'h12); wreg(4'd1, 32'h1D0); wreg(4'd4, 32'd0);
      nlog = 0;
      wreg(4'd0, 32'hD000_0060);
      rreg(4'd10, d); chk("R2 busy visible", d, 32'd1);
      wait_idle();
      chk("R4 erase byte count", 32'(nlog), 32'd5);
      chk("R3 opcode with CLE", 32'(blog[0]), 32'h260);
      chk("R4 addr byte 0", 32'(blog[1]), 32'h156);
      chk("R4 addr byte 1", 32'(blog[2]), 32'h134);
      chk("R4 addr byte 2", 32'(blog[3]), 32'h112);
      chk("R7 confirm with CLE", 32'(blog[4]), 32'h2D0);
      rreg(4'd8, d); chk("R9 done flag, no data flag (R6)", d, 32'h8000_0000);
      wreg(4'd8, 32'h8000_0000);
      rreg(4'd8, d); chk("R9 write-one clear", d, 32'd0);
   endtask

   task automatic t_program;
      logic [31:0] d;
      logic [9:0] exp [0:10];
      exp = '{10'h280, 10'h100, 10'h101, 10'h101, 10'h102, 10'h103,
              10'h011, 10'h022, 10'h033, 10'h044, 10'h210};
      bwr(0, 8'h11); bwr(1, 8'h22); bwr(2, 8'h33); bwr(3, 8'h44);
      wreg(4'd4, 32'd4); wreg(4'd2, 32'h0100); wreg(4'd3, 32'h030201); wreg(4'd1, 32'h110);
      nlog = 0;
      wreg(4'd0, 32'hE200_0080);
      wait_idle();
      chk("R5 program byte count", 32'(nlog), 32'd11);
      for (int i = 0; i < 11; i++) chk("R5 program sequence", 32'(blog[i]), 32'(exp[i]));
      rreg(4'd8, d); chk("R9 done and data flags", d, 32'h9000_0000);
      wreg(4'd8, 32'hFFFF_FFFF);
   endtask

   task automatic t_readid;
      logic [31:0] d;
      logic [7:0] b;
      bwr(5, 8'h5A);
      wreg(4'd1, 32'h0); wreg(4'd4, 32'd5); wreg(4'd2, 32'h0);
      nlog = 0; rcount = 0;
      wreg(4'd0, 32'hC400_0090);
      wait_idle();
      chk("R6 read pulses", 32'(rcount), 32'd5);
      for (int i = 0; i < 5; i++) begin
         brd(i, b); chk("R6 captured byte", 32'(b), 32'(8'hA0 + 8'(i)));
      end
      brd(5, b); chk("R6 byte past length untouched", 32'(b), 32'h5A);
      chk("R7 no second command", 32'(nlog), 32'd2);
      chk("R4 single address cycle", 32'(blog[1]), 32'h100);
      rreg(4'd8, d); chk("R9 read flags", d, 32'h9000_0000);
      wreg(4'd8, 32'hFFFF_FFFF);
   endtask

   task automatic t_timing;
      wreg(4'd5, 32'h0001_0203); wreg(4'd6, 32'd20);
      wreg(4'd0, 32'h8000_00FF);
      wait_idle();
      chk("R10 WE low width 3", 32'(wlast), 32'd3);
      chk("R8 last WE rise to release", 32'(glast), 32'd23);
      wreg(4'd5, 32'h0); wreg(4'd6, 32'h0);
      wreg(4'd0, 32'h8000_00FF);
      wait_idle();
      chk("R10 zero field is one clock", 32'(wlast), 32'd1);
      wreg(4'd8, 32'hFFFF_FFFF);
   endtask

   task automatic t_busy_go;
      logic [31:0] d;
      rb = 1'b0;
      wreg(4'd7, 32'd1000);
      nlog = 0;
      wreg(4'd0, 32'h8000_0070);
      repeat (20) @(negedge clk);
      wreg(4'd0, 32'h8000_0011);
      rreg(4'd0, d); chk("R11 launch ignored while busy", d, 32'h8000_0070);
      rb = 1'b1;
      wait_idle();
      chk("R11 no extra bus bytes", 32'(nlog), 32'd1);
      rreg(4'd8, d); chk("R9 done after ready", d, 32'h8000_0000);
      wreg(4'd8, 32'hFFFF_FFFF);
   endtask

   task automatic t_timeout;
      logic [31:0] d;
      wreg(4'd9, 32'h8000_0001);
      wreg(4'd7, 32'd50);
      rb = 1'b0;
      wreg(4'd0, 32'h8000_0070);
      wait_idle();
      rreg(4'd8, d); chk("R12 timeout flag only", d, 32'h0000_0001);
      @(negedge clk); chk("R9 irq from timeout", 32'(irq), 32'd1);
      wreg(4'd8, 32'h1);
      @(negedge clk); chk("R9 irq cleared", 32'(irq), 32'd0);
      rb = 1'b1;
      wreg(4'd0, 32'h8000_00FF);
      wait_idle();
      @(negedge clk); chk("R9 irq from done", 32'(irq), 32'd1);
      wreg(4'd9, 32'h0);
      @(negedge clk); chk("R9 masked flag gives no irq", 32'(irq), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_nostart();
      t_erase();
      t_program();
      t_readid();
      t_timing();
      t_busy_go();
      t_timeout();
      finish_up();
   end
endmodule